// File: doc/BRIEF.md
# Flag Offset Register Loader

This block produces the two threshold values that a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. Both are programmed once after every reset. Which programming method applies is decided by two dual-purpose select inputs, sampled while reset is held and frozen when reset is released.

There are three methods. The first loads a fixed preset, either 8 or 16, into both offsets. The second captures both offsets from ordinary write-port data words: the almost-empty offset first, then the almost-full offset. The third shifts both offsets in one bit at a time. In that mode one select pin acts as an active-low shift enable and the other carries the data bit. A `done` output rises once the chosen method has supplied every required bit or word. Until then both offset outputs read as zero, so the flag logic downstream can ignore them.

All logic runs on the write-port clock. Reset is synchronous and active high.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `done` is 0 and both offsets read 0.
- R2: The method is `{sel_hi, sel_lo}` as sampled at the last clock edge with `rst` high. The codes are: 2'b00 parallel, 2'b01 preset 8, 2'b10 preset 16, 2'b11 serial. Changes on the select pins after reset do not change the method.
- R3: In a preset method, the first clock edge with `rst` low loads the preset into both `ae_off` and `af_off` and sets `done`.
- R4: In the parallel method, the first edge with `wr_stb` high after reset loads `ae_off` from `wr_data[OFF_W-1:0]`. The second such edge loads `af_off` from the same field and sets `done`. Bits of `wr_data` above `OFF_W-1` are ignored.
- R5: In the serial method, each clock edge with `sel_hi` low shifts in `sel_lo`. The first bit becomes the MSB of `af_off` and the last becomes the LSB of `ae_off`. `done` rises at the edge that takes bit number 2*OFF_W.
- R6: In the serial method, an edge with `sel_hi` high shifts nothing and does not advance the bit count.
- R7: Bits or words that arrive after `done` has risen leave both offsets unchanged.
- R8: Both offsets read 0 while `done` is 0.
- R9: Once high, `done` stays high until the next reset. A new reset clears it and restarts programming.
- R10: The select pins have no effect in the parallel and preset methods, and `wr_stb` has no effect in the serial and preset methods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-port clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_hi | input | 1 | Method select bit 1; serial shift enable, active low, after reset |
| sel_lo | input | 1 | Method select bit 0; serial data bit after reset |
| wr_stb | input | 1 | Write-port data strobe |
| wr_data | input | DATA_W | Write-port data word |
| ae_off | output | OFF_W | Almost-empty offset |
| af_off | output | OFF_W | Almost-full offset |
| done | output | 1 | Offsets programmed and valid |

## Verification
The serial method is the hardest path to drive from the ports. The same pins select the method during reset and then carry the enable and the data, so the stimulus must hold both pins at 1 on the last reset edge and only afterwards begin clocking bits. The bench sends streams of 2*OFF_W bits separated by idle cycles with the enable held high. It then keeps shifting after completion and also raises `wr_stb`, to show that neither changes the outputs. A reset partway through a stream shows that the count restarts from zero.

// File: rtl/fol_pkg.sv
package fol_pkg;
  typedef enum logic [1:0] {
    M_PAR   = 2'b00,
    M_PRE_A = 2'b01,
    M_PRE_B = 2'b10,
    M_SER   = 2'b11
  } method_e;
endpackage

// File: rtl/fol_method_latch.sv
module fol_method_latch
  import fol_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sel_hi,
  input  logic    sel_lo,
  output method_e method_q
);
  // Tracks the select pins while reset is asserted; frozen once it drops.
  always_ff @(posedge clk) begin
    if (rst) method_q <= method_e'({sel_hi, sel_lo});
  end
endmodule

// File: rtl/fol_serial_chain.sv
module fol_serial_chain #(
  parameter int OFF_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             shift_n,
  input  logic             sdat,
  output logic [OFF_W-1:0] x_val,
  output logic [OFF_W-1:0] y_val,
  output logic             done
);
  localparam int CHAIN_W = 2 * OFF_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_W - 1);

  logic [CHAIN_W-1:0] chain;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (en && !shift_n && !done) begin
      chain <= {chain[CHAIN_W-2:0], sdat};
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  assign y_val = chain[CHAIN_W-1:OFF_W];
  assign x_val = chain[OFF_W-1:0];
endmodule

// File: rtl/fol_parallel_cap.sv
module fol_parallel_cap #(
  parameter int OFF_W  = 9,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFF_W-1:0]  x_val,
  output logic [OFF_W-1:0]  y_val,
  output logic              done
);
  logic have_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_val  <= '0;
      y_val  <= '0;
      have_x <= 1'b0;
      done   <= 1'b0;
    end else if (en && wr_stb && !done) begin
      if (!have_x) begin
        x_val  <= wr_data[OFF_W-1:0];
        have_x <= 1'b1;
      end else begin
        y_val <= wr_data[OFF_W-1:0];
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import fol_pkg::*;
#(
  parameter int OFF_W    = 9,
  parameter int DATA_W   = 36,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hi,
  input  logic              sel_lo,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFF_W-1:0]  ae_off,
  output logic [OFF_W-1:0]  af_off,
  output logic              done
);
  localparam logic [OFF_W-1:0] PA = OFF_W'(PRESET_A);
  localparam logic [OFF_W-1:0] PB = OFF_W'(PRESET_B);

  method_e          method_q;
  logic [OFF_W-1:0] ser_x, ser_y, par_x, par_y, pre_val;
  logic             ser_done, par_done, pre_done;
  logic             is_ser, is_par, is_pre;

  assign is_ser = (method_q == M_SER);
  assign is_par = (method_q == M_PAR);
  assign is_pre = (method_q == M_PRE_A) || (method_q == M_PRE_B);

  fol_method_latch u_latch (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .method_q(method_q)
  );

  fol_serial_chain #(.OFF_W(OFF_W)) u_ser (
    .clk(clk), .rst(rst), .en(is_ser), .shift_n(sel_hi), .sdat(sel_lo),
    .x_val(ser_x), .y_val(ser_y), .done(ser_done)
  );

  fol_parallel_cap #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_par (
    .clk(clk), .rst(rst), .en(is_par), .wr_stb(wr_stb), .wr_data(wr_data),
    .x_val(par_x), .y_val(par_y), .done(par_done)
  );

  // Preset path: one register for the value, one for completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_val  <= '0;
      pre_done <= 1'b0;
    end else if (is_pre && !pre_done) begin
      pre_val  <= (method_q == M_PRE_B) ? PB : PA;
      pre_done <= 1'b1;
    end
  end

  always_comb begin
    done   = 1'b0;
    ae_off = '0;
    af_off = '0;
    unique case (method_q)
      M_SER: begin
        done = ser_done;
        if (ser_done) begin ae_off = ser_x; af_off = ser_y; end
      end
      M_PAR: begin
        done = par_done;
        if (par_done) begin ae_off = par_x; af_off = par_y; end
      end
      default: begin
        done = pre_done;
        if (pre_done) begin ae_off = pre_val; af_off = pre_val; end
      end
    endcase
  end
endmodule

// File: rtl/fol_checker.sv
module fol_checker #(
  parameter int OFF_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       method,
  input logic             sel_hi,
  input logic             wr_stb,
  input logic             done,
  input logic [OFF_W-1:0] ae_off,
  input logic [OFF_W-1:0] af_off
);
  // R9: completion is sticky until reset
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R8: offsets hidden until programming completes
  a_r8_zero_until_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> (ae_off == '0 && af_off == '0));

  // R7: offsets frozen after completion
  a_r7_frozen_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(ae_off) && $stable(af_off)));

  // R3: preset methods finish at the first edge out of reset
  a_r3_preset_prompt: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (method == 2'b01 || method == 2'b10)) |=> done);

  // R5: serial completion only follows an enabled shift
  a_r5_serial_needs_shift: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && method == 2'b11) |-> $past(!sel_hi));

  // R4: parallel completion only follows a write
  a_r4_parallel_needs_write: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && method == 2'b00) |-> $past(wr_stb));
endmodule

bind flag_offset_loader fol_checker #(.OFF_W(OFF_W)) u_fol_chk (
  .clk(clk), .rst(rst), .method(method_q), .sel_hi(sel_hi), .wr_stb(wr_stb),
  .done(done), .ae_off(ae_off), .af_off(af_off)
);

// File: tb/flag_offset_loader_bench.sv
module flag_offset_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W  = 9;
  localparam int DATA_W = 36;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel_hi = 1'b0, sel_lo = 1'b0, wr_stb = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [OFF_W-1:0]  ae_off, af_off;
  logic              done;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  flag_offset_loader #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_flag_offset_loader (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .wr_stb(wr_stb),
    .wr_data(wr_data), .ae_off(ae_off), .af_off(af_off), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_method = 0;
  bit m_done = 0;
  int m_x = 0, m_y = 0;
  bit bitq[$];
  int wordq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_method = {sel_hi, sel_lo};
      m_done = 0; m_x = 0; m_y = 0;
      bitq.delete(); wordq.delete();
    end else if (!m_done) begin
      if (m_method == 1 || m_method == 2) begin
        m_x = (m_method == 1) ? 8 : 16; m_y = m_x; m_done = 1;
      end else if (m_method == 3 && !sel_hi) begin
        bitq.push_back(sel_lo);
        if (bitq.size() == 2*OFF_W) begin
          m_y = 0; m_x = 0;
          for (int i = 0; i < OFF_W; i++) m_y = (m_y << 1) | bitq[i];
          for (int i = OFF_W; i < 2*OFF_W; i++) m_x = (m_x << 1) | bitq[i];
          m_done = 1;
        end
      end else if (m_method == 0 && wr_stb) begin
        wordq.push_back(int'(wr_data[OFF_W-1:0]));
        if (wordq.size() == 2) begin m_x = wordq[0]; m_y = wordq[1]; m_done = 1; end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    int ex, ey;
    ex = m_done ? m_x : 0;
    ey = m_done ? m_y : 0;
    checks++;
    if (done !== m_done || int'(ae_off) !== ex || int'(af_off) !== ey) begin
      errors++;
      $display("FAIL %s: done=%0b ae=%0d af=%0d expected done=%0b ae=%0d af=%0d",
               tag, done, ae_off, af_off, m_done, ex, ey);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_vals(string t, bit d, int x, int y);
    checks++;
    if (done !== d || int'(ae_off) !== x || int'(af_off) !== y) begin
      errors++;
      $display("FAIL %s: done=%0b ae=%0d af=%0d expected done=%0b ae=%0d af=%0d",
               t, done, ae_off, af_off, d, x, y);
    end
  endtask

  task automatic do_reset(bit hi, bit lo);
    rst = 1; wr_stb = 0;
    sel_hi = ~hi; sel_lo = ~lo; tick(2);   // R2: earlier values are overwritten
    sel_hi = hi; sel_lo = lo; tick(1);
    rst = 0;
  endtask

  task automatic ser_send(int y, int x, int gap_every);
    for (int i = 2*OFF_W-1; i >= 0; i--) begin
      bit b;
      b = (i >= OFF_W) ? y[i-OFF_W] : x[i];
      if (gap_every != 0 && i % gap_every == 0) begin
        sel_hi = 1; sel_lo = ~b; tick(1);   // R6: idle edge
      end
      sel_hi = 0; sel_lo = b; tick(1);
    end
    sel_hi = 1;
  endtask

  initial begin
    tag = "R1"; do_reset(1'b0, 1'b1);
    expect_vals("R1", 0, 0, 0);
    tag = "R3"; tick(1);
    expect_vals("R3", 1, 8, 8);
    tag = "R10"; sel_hi = 0; sel_lo = 1; wr_stb = 1; wr_data = 36'h3;
    tick(3); wr_stb = 0;
    expect_vals("R10", 1, 8, 8);

    tag = "R2"; do_reset(1'b1, 1'b0); tick(1);
    expect_vals("R3", 1, 16, 16);

    tag = "R4"; do_reset(1'b0, 1'b0);
    sel_hi = 0; sel_lo = 1; tick(2);     // R10: serial pins ignored
    expect_vals("R10", 0, 0, 0);
    wr_stb = 1; wr_data = 36'hF_0000_0005; tick(1); wr_stb = 0;
    expect_vals("R8", 0, 0, 0);
    tick(2);
    wr_stb = 1; wr_data = 36'hA_0000_01FF; tick(1);
    expect_vals("R4", 1, 5, 511);
    tag = "R7"; wr_data = 36'h1; tick(2); wr_stb = 0;
    expect_vals("R7", 1, 5, 511);

    tag = "R5"; do_reset(1'b1, 1'b1);
    wr_stb = 1; wr_data = 36'h7; tick(2); wr_stb = 0;  // R10
    ser_send(9'h155, 9'h0C3, 0);
    expect_vals("R5", 1, 'h0C3, 'h155);
    tag = "R7"; sel_hi = 0; sel_lo = 1; tick(4); sel_hi = 1;
    expect_vals("R7", 1, 'h0C3, 'h155);

    tag = "R6"; do_reset(1'b1, 1'b1);
    ser_send(9'h101, 9'h0FE, 3);
    expect_vals("R6", 1, 'h0FE, 'h101);

    tag = "R9"; do_reset(1'b1, 1'b1);
    sel_hi = 0; sel_lo = 1; tick(5); sel_hi = 1;
    do_reset(1'b1, 1'b1);
    expect_vals("R9", 0, 0, 0);
    ser_send(9'h00A, 9'h1F0, 0);
    expect_vals("R9", 1, 'h1F0, 'h00A);
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule